// File: doc/BRIEF.md
# Time-Aware Gate Scheduler

This block sets the transmission gates of one egress port from a cyclic schedule. The schedule is a short list. Each entry gives the open or closed state of the eight priority-queue gates, a guard-band flag and a duration. Durations are counted in steps of 2048 ns, and each step is taken from the network-wide synchronized time. Every switch that shares that time therefore changes its gates at the same instants. A queue arbiter downstream uses the gate vector to choose which queues may send.

When the current entry has its guard band set, the block reports how many nanoseconds remain before the entry ends. It also answers whether a frame of a given duration may start. A frame may start only if it finishes before the gates change. Software loads gate states, durations and the index of the last active entry through a simple write port addressed by list index. Durations kept in software in 16384 ns units must be multiplied by 8 before they are written.

Top module: `tas_gate_sched`

## Requirements
- R1: While the schedule runs, `gateOpen` equals bits 7..0 of the current entry, and `guardOn` equals its bit 8. Bit 0 is the gate of the first queue, so entry 9'h101 opens only queue 0 with the guard band on.
- R2: While `enable` is low, `gateOpen` is 8'hFF, `guardOn` is 0 and `txOk` is 1. These values appear in the same cycle that `enable` falls.
- R3: On the first rising clock edge that sees `enable` high after it was low, the schedule starts at entry 0 with that entry's full duration loaded.
- R4: A tick is a clock edge at which `syncTime[47:11]` differs from its value at the previous edge. Each tick consumes one unit of the current entry. The entry changes at the tick that consumes its last unit.
- R5: A duration value of 0 is treated as 1 unit.
- R6: The entry that follows index `lastIdx` is entry 0. `lastIdx` is written with kind code 2, so with `lastIdx` = 0 a single entry repeats.
- R7: While running, `remainingNs` equals the units left × 2048 − `syncTime[10:0]`.
- R8: `txOk` is 1 when `guardOn` is 0. Otherwise `txOk` is 1 exactly when `frameNs` ≤ `remainingNs`.
- R9: A write with `cfgWe` high stores `cfgData` at the next clock edge. Kind 0 stores `cfgData[8:0]` as the entry at `cfgIdx`, and kind 1 stores `cfgData[15:0]` as the duration at `cfgIdx`. After reset every entry is 9'h0FF, every duration is 0 and `lastIdx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the schedule; low holds all gates open |
| syncTime | input | 48 | Synchronized time in ns |
| cfgWe | input | 1 | Configuration write strobe |
| cfgKind | input | 2 | 0 entry, 1 duration, 2 last index |
| cfgIdx | input | 3 | List index of the write |
| cfgData | input | 16 | Write data |
| frameNs | input | 27 | Transmission time of the candidate frame in ns |
| gateOpen | output | 8 | Per-queue gate open vector |
| guardOn | output | 1 | Guard band of current entry active |
| remainingNs | output | 27 | Time left in current entry |
| txOk | output | 1 | Candidate frame may start |

## Verification
On every cycle the assertions check the following. The list index stays put between ticks and otherwise only advances by one or wraps to zero. A unit is consumed only when more than one is left. The reported remaining time never reaches zero while running. Stopping the schedule always returns it to entry 0. The order of gate vectors, the conversion of a zero duration, the wrap after the last active entry and the exact remaining-time values appear only in the bench's scenarios. The bench also shows the frame-fit decision at the boundary values and the immediate opening of all gates on disable.

// File: rtl/tas_pkg.sv
package tas_pkg;
  typedef enum logic [1:0] {
    CFG_GATE = 2'd0,
    CFG_INTV = 2'd1,
    CFG_LAST = 2'd2
  } cfgKind_e;

  // Control-to-datapath strobes for the unit counter
  typedef struct packed {
    logic reload;
    logic dec;
  } cntStrobe_t;
endpackage

// File: rtl/tas_ctrl.sv
module tas_ctrl
  import tas_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int SYNC_W     = 48,
  parameter int UNIT_SHIFT = 11,
  localparam int IDX_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [SYNC_W-1:0] syncTime,
  input  logic [IDX_W-1:0]  lastIdx,
  input  logic              lastUnit,
  output logic [IDX_W-1:0]  curIdx,
  output logic [IDX_W-1:0]  loadIdx,
  output logic              running,
  output cntStrobe_t        strobe
);
  localparam int UNIT_W = SYNC_W - UNIT_SHIFT;

  logic [UNIT_W-1:0] prevUnit;
  logic              tick;
  logic [IDX_W-1:0]  nextIdx;
  logic              startNow;

  assign tick     = syncTime[SYNC_W-1:UNIT_SHIFT] != prevUnit;
  assign startNow = enable && !running;
  assign nextIdx  = (curIdx == lastIdx) ? '0 : curIdx + IDX_W'(1);
  assign loadIdx  = startNow ? '0 : nextIdx;

  always_comb begin
    strobe = '0;
    if (startNow) begin
      strobe.reload = 1'b1;
    end else if (enable && tick) begin
      if (lastUnit) strobe.reload = 1'b1;
      else          strobe.dec    = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prevUnit <= '0;
    else     prevUnit <= syncTime[SYNC_W-1:UNIT_SHIFT];
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      running <= 1'b0;
      curIdx  <= '0;
    end else if (!running) begin
      running <= 1'b1;
      curIdx  <= '0;
    end else if (tick && lastUnit) begin
      curIdx  <= nextIdx;
    end
  end

  // R4
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && running && !tick) |=> (curIdx == $past(curIdx)));

  // R3
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (curIdx == '0 && !running));

  // R6
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (running && $past(running) && curIdx != $past(curIdx)) |->
      (curIdx == '0 || curIdx == $past(curIdx) + IDX_W'(1)));
endmodule

// File: rtl/tas_path.sv
module tas_path
  import tas_pkg::*;
#(
  parameter int QUEUES     = 8,
  parameter int DEPTH      = 8,
  parameter int INTV_W     = 16,
  parameter int UNIT_SHIFT = 11,
  parameter int CFG_DW     = 16,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int ENT_W     = QUEUES + 1,
  localparam int REM_W     = INTV_W + UNIT_SHIFT
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfgWe,
  input  logic [1:0]            cfgKind,
  input  logic [IDX_W-1:0]      cfgIdx,
  input  logic [CFG_DW-1:0]     cfgData,
  input  cntStrobe_t            strobe,
  input  logic [IDX_W-1:0]      loadIdx,
  input  logic [IDX_W-1:0]      curIdx,
  input  logic                  active,
  input  logic [UNIT_SHIFT-1:0] phase,
  input  logic [REM_W-1:0]      frameNs,
  output logic [IDX_W-1:0]      lastIdx,
  output logic                  lastUnit,
  output logic [QUEUES-1:0]     gateOpen,
  output logic                  guardOn,
  output logic [REM_W-1:0]      remainingNs,
  output logic                  txOk
);
  logic [ENT_W-1:0]  gateMem [DEPTH];
  logic [INTV_W-1:0] intvMem [DEPTH];
  logic [INTV_W-1:0] unitsLeft;
  logic [INTV_W-1:0] loadVal;
  logic [ENT_W-1:0]  entry;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        gateMem[i] <= {1'b0, {QUEUES{1'b1}}};
        intvMem[i] <= '0;
      end
      lastIdx <= '0;
    end else if (cfgWe) begin
      case (cfgKind_e'(cfgKind))
        CFG_GATE: gateMem[cfgIdx] <= cfgData[ENT_W-1:0];
        CFG_INTV: intvMem[cfgIdx] <= cfgData[INTV_W-1:0];
        CFG_LAST: lastIdx         <= cfgData[IDX_W-1:0];
        default:  ;
      endcase
    end
  end

  assign loadVal = (intvMem[loadIdx] == '0) ? INTV_W'(1) : intvMem[loadIdx];

  always_ff @(posedge clk) begin
    if (rst)               unitsLeft <= '0;
    else if (strobe.reload) unitsLeft <= loadVal;
    else if (strobe.dec)    unitsLeft <= unitsLeft - INTV_W'(1);
  end

  assign lastUnit    = unitsLeft == INTV_W'(1);
  assign entry       = gateMem[curIdx];
  assign gateOpen    = active ? entry[QUEUES-1:0] : {QUEUES{1'b1}};
  assign guardOn     = active && entry[QUEUES];
  assign remainingNs = {unitsLeft, {UNIT_SHIFT{1'b0}}} - {{INTV_W{1'b0}}, phase};
  assign txOk        = !guardOn || (frameNs <= remainingNs);

  // R4
  dec_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.dec |-> (unitsLeft > INTV_W'(1)));
endmodule

// File: rtl/tas_gate_sched.sv
module tas_gate_sched
  import tas_pkg::*;
#(
  parameter int QUEUES     = 8,
  parameter int DEPTH      = 8,
  parameter int INTV_W     = 16,
  parameter int SYNC_W     = 48,
  parameter int UNIT_SHIFT = 11,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int ENT_W     = QUEUES + 1,
  localparam int REM_W     = INTV_W + UNIT_SHIFT,
  localparam int CFG_DW    = (INTV_W > ENT_W) ? INTV_W : ENT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [SYNC_W-1:0] syncTime,
  input  logic              cfgWe,
  input  logic [1:0]        cfgKind,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [CFG_DW-1:0] cfgData,
  input  logic [REM_W-1:0]  frameNs,
  output logic [QUEUES-1:0] gateOpen,
  output logic              guardOn,
  output logic [REM_W-1:0]  remainingNs,
  output logic              txOk
);
  cntStrobe_t       strobe;
  logic [IDX_W-1:0] curIdx;
  logic [IDX_W-1:0] loadIdx;
  logic [IDX_W-1:0] lastIdx;
  logic             lastUnit;
  logic             running;

  tas_ctrl #(
    .DEPTH(DEPTH), .SYNC_W(SYNC_W), .UNIT_SHIFT(UNIT_SHIFT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .syncTime(syncTime),
    .lastIdx(lastIdx), .lastUnit(lastUnit), .curIdx(curIdx),
    .loadIdx(loadIdx), .running(running), .strobe(strobe)
  );

  tas_path #(
    .QUEUES(QUEUES), .DEPTH(DEPTH), .INTV_W(INTV_W),
    .UNIT_SHIFT(UNIT_SHIFT), .CFG_DW(CFG_DW)
  ) u_path (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgKind(cfgKind),
    .cfgIdx(cfgIdx), .cfgData(cfgData), .strobe(strobe),
    .loadIdx(loadIdx), .curIdx(curIdx), .active(enable && running),
    .phase(syncTime[UNIT_SHIFT-1:0]), .frameNs(frameNs),
    .lastIdx(lastIdx), .lastUnit(lastUnit), .gateOpen(gateOpen),
    .guardOn(guardOn), .remainingNs(remainingNs), .txOk(txOk)
  );

  // R7
  rem_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && running) |-> (remainingNs != '0));
endmodule

// File: tb/sim_tas_gate_sched.sv
module sim_tas_gate_sched;
  logic        clk = 1'b0;
  logic        rst;
  logic        enable;
  logic [47:0] syncTime;
  logic        cfgWe;
  logic [1:0]  cfgKind;
  logic [2:0]  cfgIdx;
  logic [15:0] cfgData;
  logic [26:0] frameNs;
  logic [7:0]  gateOpen;
  logic        guardOn;
  logic [26:0] remainingNs;
  logic        txOk;

  int checks = 0;
  int errors = 0;
  longint unitNow = 5;

  always #2 clk = ~clk;

  tas_gate_sched u0 (
    .clk(clk), .rst(rst), .enable(enable), .syncTime(syncTime),
    .cfgWe(cfgWe), .cfgKind(cfgKind), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .frameNs(frameNs), .gateOpen(gateOpen), .guardOn(guardOn),
    .remainingNs(remainingNs), .txOk(txOk)
  );

  typedef struct packed {
    logic        inc;
    logic [10:0] phase;
    logic [26:0] frame;
    logic [7:0]  gate;
    logic        guard;
    logic [26:0] rem;
    logic        ok;
  } row_t;

  // schedule: e0=9'h101 x2, e1=9'h0F0 x0(->1), e2=9'h03C x3, last index 2
  localparam row_t TBL [11] = '{
    '{1'b0, 11'd100,  27'd3996, 8'h01, 1'b1, 27'd3996, 1'b1},
    '{1'b0, 11'd200,  27'd3897, 8'h01, 1'b1, 27'd3896, 1'b0},
    '{1'b1, 11'd0,    27'd2048, 8'h01, 1'b1, 27'd2048, 1'b1},
    '{1'b1, 11'd500,  27'd5000, 8'hF0, 1'b0, 27'd1548, 1'b1},
    '{1'b1, 11'd0,    27'd0,    8'h3C, 1'b0, 27'd6144, 1'b1},
    '{1'b1, 11'd10,   27'd0,    8'h3C, 1'b0, 27'd4086, 1'b1},
    '{1'b1, 11'd0,    27'd0,    8'h3C, 1'b0, 27'd2048, 1'b1},
    '{1'b1, 11'd2047, 27'd2050, 8'h01, 1'b1, 27'd2049, 1'b0},
    '{1'b0, 11'd2047, 27'd2049, 8'h01, 1'b1, 27'd2049, 1'b1},
    '{1'b1, 11'd1,    27'd2047, 8'h01, 1'b1, 27'd2047, 1'b1},
    '{1'b1, 11'd0,    27'd0,    8'hF0, 1'b0, 27'd2048, 1'b1}
  };

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(logic [1:0] kind, logic [2:0] idx, logic [15:0] data);
    cfgWe = 1'b1; cfgKind = kind; cfgIdx = idx; cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic setTime(logic inc, logic [10:0] phase);
    if (inc) unitNow++;
    syncTime = 48'(unitNow * 2048) + 48'(phase);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rst = 1'b1; enable = 1'b0; cfgWe = 1'b0; cfgKind = '0; cfgIdx = '0;
    cfgData = '0; frameNs = '1;
    setTime(1'b0, 11'd100);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2: idle after reset
    check("R2 idle gates", gateOpen, 8'hFF);
    check("R2 idle guard", guardOn, 0);
    check("R2 idle txOk", txOk, 1);

    // R9/R5: reset entry 9'h0FF, duration 0 -> 1 unit
    enable = 1'b1;
    @(negedge clk);
    check("R9 reset entry gates", gateOpen, 8'hFF);
    check("R9 reset entry guard", guardOn, 0);
    check("R5 reset duration", remainingNs, 2048 - 100);
    enable = 1'b0;
    @(negedge clk);

    cfgWrite(2'd0, 3'd0, 16'h0101);
    cfgWrite(2'd1, 3'd0, 16'd2);
    cfgWrite(2'd0, 3'd1, 16'h00F0);
    cfgWrite(2'd1, 3'd1, 16'd0);
    cfgWrite(2'd0, 3'd2, 16'h003C);
    cfgWrite(2'd1, 3'd2, 16'd3);
    cfgWrite(2'd2, 3'd0, 16'd2);

    // R1 R3 R4 R5 R6 R7 R8: schedule walk
    enable = 1'b1;
    for (int i = 0; i < 11; i++) begin
      setTime(TBL[i].inc, TBL[i].phase);
      frameNs = TBL[i].frame;
      @(negedge clk);
      check($sformatf("R1 row%0d gates", i), gateOpen, TBL[i].gate);
      check($sformatf("R1 row%0d guard", i), guardOn, TBL[i].guard);
      check($sformatf("R7 row%0d remaining", i), remainingNs, TBL[i].rem);
      check($sformatf("R8 row%0d txOk", i), txOk, TBL[i].ok);
    end

    // R2: disable takes effect combinationally
    enable = 1'b0;
    frameNs = '1;
    #1;
    check("R2 disable same cycle gates", gateOpen, 8'hFF);
    check("R2 disable same cycle guard", guardOn, 0);
    check("R2 disable txOk", txOk, 1);
    @(negedge clk);
    check("R2 disabled gates", gateOpen, 8'hFF);

    // R6: single active entry; R3 restart at entry 0
    cfgWrite(2'd2, 3'd0, 16'd0);
    enable = 1'b1;
    setTime(1'b1, 11'd0);
    @(negedge clk);
    check("R3 restart gates", gateOpen, 8'h01);
    check("R3 restart remaining", remainingNs, 4096);
    setTime(1'b1, 11'd0);
    @(negedge clk);
    check("R4 one unit left", remainingNs, 2048);
    setTime(1'b1, 11'd0);
    @(negedge clk);
    check("R6 single entry repeats gates", gateOpen, 8'h01);
    check("R6 single entry reload", remainingNs, 4096);

    finishRun();
  end
endmodule